// File: doc/BRIEF.md
# Accelerator Slice Gate with Suspend and Purge

This block sits between one accelerator slice and the host side of a chip. The accelerator offers requests over a valid/ready handshake. They wait in a small first-in first-out queue and are issued toward the host over a second valid/ready handshake. Each issued transaction stays outstanding until the host returns a one-cycle completion pulse. A single 64-bit control word, written in one strobed access and always readable, governs the slice. It holds a configuration lock, a 16-bit programming-model value, a suspend request and a purge request. It also reports a read-only status code for each of the two requests.

A suspend stops issue from the queue. The accelerator may keep filling the queue, and transactions already in flight are left to finish. A purge throws away everything in the queue and refuses new requests. Its status moves from "in progress" to "complete" once the queue is empty and nothing remains outstanding. The slice returns to normal operation only when software writes the request bit back to zero. While the configuration lock is set, the slice cannot be enabled. The low byte of the programming-model value and three of its feature enables are decoded onto dedicated outputs.

Top module: `slice_gate_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the lock bit (word bit 48, counted from bit 0 as the LSB) to 1 and clears every other bit of the word. It also empties the queue and clears the outstanding count.
- R2: On `csr_we` the word is loaded from `csr_wdata` and is readable on `csr_rdata` from the next cycle. The writable fields are: lock at bit 48, programming model at bits 47:32, purge request at bit 15 and suspend request at bit 0.
- R3: `cfg_model` equals word bits 39:32. `cfg_lpid_chk` is bit 41, `cfg_pid_chk` is bit 42 and `cfg_lpc_en` is bit 43.
- R4: While the suspend bit is 1, `host_valid` is 0. `acc_ready` still follows queue space, so requests keep being accepted.
- R5: While the purge bit is 1, `acc_ready` and `host_valid` are 0. The queue is emptied at the first clock edge that sees the bit set.
- R6: The purge status sits at bits 25:24. It reads 00 while the purge bit is 0. It reads 01 while the purge bit is 1 and the purge has not finished. It reads 11 from the cycle after an edge at which the purge bit was 1, the queue was empty and nothing was outstanding. It never reads 10.
- R7: The suspend status sits at bits 9:8. It reads 01 while the suspend bit is 1 and at least one issued transaction is outstanding, and 00 otherwise.
- R8: Written values for the status fields and for all reserved bits are ignored. Those reserved bits always read 0.
- R9: `slice_active` is `slice_enable` AND NOT lock. It is 0 whenever the lock bit is 1.
- R10: With neither request set, requests leave in arrival order. `acc_ready` is 0 only when the queue holds DEPTH entries. `host_valid` is 0 when the queue is empty or MAX_OUT transactions are outstanding. A completion pulse with nothing outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_we | input | 1 | Write strobe for the control word |
| csr_wdata | input | 64 | Control word write data |
| csr_rdata | output | 64 | Control word read data with status |
| slice_enable | input | 1 | Request to enable the accelerator |
| slice_active | output | 1 | Enable granted (blocked by lock) |
| cfg_model | output | 8 | Model-type byte of the programming model |
| cfg_lpid_chk | output | 1 | Partition-id check feature enable |
| cfg_pid_chk | output | 1 | Process-id check feature enable |
| cfg_lpc_en | output | 1 | Lowest-point-of-coherency feature enable |
| acc_valid | input | 1 | Accelerator request valid |
| acc_ready | output | 1 | Request accepted into the queue |
| acc_data | input | DATA_W | Accelerator request payload |
| host_valid | output | 1 | Queue head offered to the host |
| host_ready | input | 1 | Host takes the offered transaction |
| host_data | output | DATA_W | Payload of the queue head |
| host_done | input | 1 | Completion pulse for one outstanding transaction |

## Verification
The bench suspends the slice while transactions are in flight and watches the suspend status fall back to 00 as completions arrive. A design that tied that status to the request bit alone would hold 01 after the drain. It purges with a full queue and with transactions outstanding, then holds back completions. A purge status that reached 11 without waiting for the outstanding count, or that never returned to 00 on clear, shows up in the read word. It writes all ones to the word to catch status or reserved bits that take written values. It runs long random traffic against the queue's full, empty and outstanding-limit edges. A wrong pop order or a completion accepted at zero would corrupt the payload or the issue gating.

// File: rtl/slice_ctl_pkg.sv
`timescale 1ns/1ps
package slice_ctl_pkg;

   localparam int CSR_W = 64;

   // the word is numbered from its MSB; convert to vector index
   function automatic int msb0(input int b);
      return CSR_W - 1 - b;
   endfunction

   localparam int CR_IX   = msb0(15);
   localparam int PM_HI   = msb0(16);
   localparam int PM_LO   = msb0(31);
   localparam int PS_HI   = msb0(38);
   localparam int PS_LO   = msb0(39);
   localparam int PC_IX   = msb0(48);
   localparam int SS_HI   = msb0(54);
   localparam int SS_LO   = msb0(55);
   localparam int SC_IX   = msb0(63);

   localparam int PM_W      = PM_HI - PM_LO + 1;
   localparam int MODEL_W   = 8;
   localparam int FEAT_LPID = msb0(22) - PM_LO;
   localparam int FEAT_PID  = msb0(21) - PM_LO;
   localparam int FEAT_LPC  = msb0(20) - PM_LO;

   typedef enum logic [1:0] {
      PURGE_IDLE = 2'b00,
      PURGE_BUSY = 2'b01,
      PURGE_DONE = 2'b11
   } purge_st_e;

   typedef enum logic [1:0] {
      SUSP_RUN   = 2'b00,
      SUSP_DRAIN = 2'b01
   } susp_st_e;

   typedef struct packed {
      logic            cr;
      logic [PM_W-1:0] pm;
      logic            pc;
      logic            sc;
   } ctl_t;

   function automatic logic [CSR_W-1:0] pack_csr(input ctl_t c,
                                                 input purge_st_e ps,
                                                 input susp_st_e ss);
      logic [CSR_W-1:0] w;
      w                = '0;
      w[CR_IX]         = c.cr;
      w[PM_HI:PM_LO]   = c.pm;
      w[PS_HI:PS_LO]   = ps;
      w[PC_IX]         = c.pc;
      w[SS_HI:SS_LO]   = ss;
      w[SC_IX]         = c.sc;
      return w;
   endfunction

endpackage

// File: rtl/slice_ctl_regs.sv
`timescale 1ns/1ps
module slice_ctl_regs
   import slice_ctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [CSR_W-1:0] wdata,
   output ctl_t             ctl
);

   // status and reserved bits of the write word are dropped here
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl.cr <= 1'b1;
         ctl.pm <= '0;
         ctl.pc <= 1'b0;
         ctl.sc <= 1'b0;
      end else if (we) begin
         ctl.cr <= wdata[CR_IX];
         ctl.pm <= wdata[PM_HI:PM_LO];
         ctl.pc <= wdata[PC_IX];
         ctl.sc <= wdata[SC_IX];
      end
   end

endmodule

// File: rtl/slice_req_fifo.sv
`timescale 1ns/1ps
module slice_req_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = ((1 << PTR_W) == DEPTH);

   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic [DEPTH-1:0][W-1:0] slots;

   generate
      if (POW2) begin : g_wrap_free
         always_comb begin
            wr_nxt = wr_ptr + 1'b1;
            rd_nxt = rd_ptr + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         end
      end
   endgenerate

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
         if (push && !flush && (wr_ptr == PTR_W'(i)))
            q_r <= din;
      end
      assign slots[i] = q_r;
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   assign dout  = slots[rd_ptr];
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

endmodule

// File: rtl/slice_issue_track.sv
`timescale 1ns/1ps
module slice_issue_track
   import slice_ctl_pkg::*;
#(
   parameter int MAX_OUT = 4
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      issue,
   input  logic      done,
   input  logic      purge,
   input  logic      suspend,
   input  logic      q_empty,
   output logic      at_limit,
   output purge_st_e ps,
   output susp_st_e  ss
);

   localparam int OUT_W = $clog2(MAX_OUT + 1);

   logic idle;
   logic purge_fin;

   generate
      if (MAX_OUT == 1) begin : g_flag
         logic busy;
         always_ff @(posedge clk) begin
            if (rst)        busy <= 1'b0;
            else if (issue) busy <= 1'b1;
            else if (done)  busy <= 1'b0;
         end
         assign idle     = !busy;
         assign at_limit = busy;
      end else begin : g_count
         logic [OUT_W-1:0] cnt;
         logic             retire;
         assign retire = done && (cnt != '0);
         always_ff @(posedge clk) begin
            if (rst)                    cnt <= '0;
            else if (issue && !retire)  cnt <= cnt + 1'b1;
            else if (retire && !issue)  cnt <= cnt - 1'b1;
         end
         assign idle     = (cnt == '0);
         assign at_limit = (cnt == OUT_W'(MAX_OUT));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || !purge)          purge_fin <= 1'b0;
      else if (q_empty && idle)   purge_fin <= 1'b1;
   end

   always_comb begin
      if (!purge)         ps = PURGE_IDLE;
      else if (purge_fin) ps = PURGE_DONE;
      else                ps = PURGE_BUSY;
      ss = (suspend && !idle) ? SUSP_DRAIN : SUSP_RUN;
   end

endmodule

// File: rtl/slice_gate_ctrl.sv
`timescale 1ns/1ps
module slice_gate_ctrl
   import slice_ctl_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 8,
   parameter int MAX_OUT = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 csr_we,
   input  logic [CSR_W-1:0]     csr_wdata,
   output logic [CSR_W-1:0]     csr_rdata,
   input  logic                 slice_enable,
   output logic                 slice_active,
   output logic [MODEL_W-1:0]   cfg_model,
   output logic                 cfg_lpid_chk,
   output logic                 cfg_pid_chk,
   output logic                 cfg_lpc_en,
   input  logic                 acc_valid,
   output logic                 acc_ready,
   input  logic [DATA_W-1:0]    acc_data,
   output logic                 host_valid,
   input  logic                 host_ready,
   output logic [DATA_W-1:0]    host_data,
   input  logic                 host_done
);

   if (DATA_W < 1) begin : g_bad_width
      $error("slice_gate_ctrl: DATA_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("slice_gate_ctrl: DEPTH must be at least 2");
   end
   if (MAX_OUT < 1) begin : g_bad_out
      $error("slice_gate_ctrl: MAX_OUT must be at least 1");
   end

   ctl_t      ctl;
   purge_st_e ps;
   susp_st_e  ss;
   logic      q_full, q_empty, at_limit;
   logic      push, pop;

   slice_ctl_regs u_regs (
      .clk   (clk),
      .rst   (rst),
      .we    (csr_we),
      .wdata (csr_wdata),
      .ctl   (ctl)
   );

   assign acc_ready  = !ctl.pc && !q_full;
   assign host_valid = !ctl.pc && !ctl.sc && !q_empty && !at_limit;
   assign push       = acc_valid && acc_ready;
   assign pop        = host_valid && host_ready;

   slice_req_fifo #(
      .W     (DATA_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .flush (ctl.pc),
      .push  (push),
      .din   (acc_data),
      .pop   (pop),
      .dout  (host_data),
      .full  (q_full),
      .empty (q_empty)
   );

   slice_issue_track #(
      .MAX_OUT (MAX_OUT)
   ) u_track (
      .clk      (clk),
      .rst      (rst),
      .issue    (pop),
      .done     (host_done),
      .purge    (ctl.pc),
      .suspend  (ctl.sc),
      .q_empty  (q_empty),
      .at_limit (at_limit),
      .ps       (ps),
      .ss       (ss)
   );

   assign csr_rdata    = pack_csr(ctl, ps, ss);
   assign slice_active = slice_enable && !ctl.cr;
   assign cfg_model    = ctl.pm[MODEL_W-1:0];
   assign cfg_lpid_chk = ctl.pm[FEAT_LPID];
   assign cfg_pid_chk  = ctl.pm[FEAT_PID];
   assign cfg_lpc_en   = ctl.pm[FEAT_LPC];

endmodule

// File: rtl/slice_gate_chk.sv
`timescale 1ns/1ps
module slice_gate_chk
   import slice_ctl_pkg::*;
(
   input logic             clk,
   input logic             rst,
   input logic [CSR_W-1:0] csr_rdata,
   input logic             acc_ready,
   input logic             host_valid,
   input logic             host_ready,
   input logic             slice_active
);

   // R4
   sc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      csr_rdata[SC_IX] |-> !host_valid);

   // R5
   pc_block_chk: assert property (@(posedge clk) disable iff (rst)
      csr_rdata[PC_IX] |-> (!acc_ready && !host_valid));

   // R6
   ps_code_chk: assert property (@(posedge clk) disable iff (rst)
      csr_rdata[PS_HI:PS_LO] != 2'b10);

   // R6
   ps_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !csr_rdata[PC_IX] |-> (csr_rdata[PS_HI:PS_LO] == 2'b00));

   // R7
   ss_code_chk: assert property (@(posedge clk) disable iff (rst)
      csr_rdata[SS_LO] |-> (csr_rdata[SC_IX] && !csr_rdata[SS_HI]));

   // R9
   cr_lock_chk: assert property (@(posedge clk) disable iff (rst)
      csr_rdata[CR_IX] |-> !slice_active);

   // R10
   offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (host_valid && !host_ready) |=>
         (host_valid || csr_rdata[SC_IX] || csr_rdata[PC_IX]));

endmodule

bind slice_gate_ctrl slice_gate_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .csr_rdata    (csr_rdata),
   .acc_ready    (acc_ready),
   .host_valid   (host_valid),
   .host_ready   (host_ready),
   .slice_active (slice_active)
);

// File: tb/slice_gate_ctrl_test.sv
`timescale 1ns/1ps
module slice_gate_ctrl_test;

   localparam int DW    = 16;
   localparam int DEPTH = 4;
   localparam int MOUT  = 3;
   localparam logic [63:0] USED_MASK = 64'h0001_FFFF_0300_8301;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          csr_we = 1'b0;
   logic [63:0]   csr_wdata = '0;
   logic [63:0]   csr_rdata;
   logic          slice_enable = 1'b0;
   logic          slice_active;
   logic [7:0]    cfg_model;
   logic          cfg_lpid_chk, cfg_pid_chk, cfg_lpc_en;
   logic          acc_valid = 1'b0;
   logic          acc_ready;
   logic [DW-1:0] acc_data = '0;
   logic          host_valid;
   logic          host_ready = 1'b0;
   logic [DW-1:0] host_data;
   logic          host_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int seq    = 1;

   always #5 clk = ~clk;

   slice_gate_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_OUT(MOUT)) uut (
      .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .slice_enable(slice_enable),
      .slice_active(slice_active), .cfg_model(cfg_model),
      .cfg_lpid_chk(cfg_lpid_chk), .cfg_pid_chk(cfg_pid_chk),
      .cfg_lpc_en(cfg_lpc_en), .acc_valid(acc_valid), .acc_ready(acc_ready),
      .acc_data(acc_data), .host_valid(host_valid), .host_ready(host_ready),
      .host_data(host_data), .host_done(host_done)
   );

   // behavioural reference
   bit        m_cr  = 1'b1;
   bit [15:0] m_pm  = '0;
   bit        m_pc  = 1'b0;
   bit        m_sc  = 1'b0;
   bit        m_fin = 1'b0;
   int        m_q[$];
   int        m_out = 0;
   int        sz, nout;
   bit        rdy, hv, fin, fout;

   always @(posedge clk) begin
      if (rst) begin
         m_cr = 1'b1; m_pm = '0; m_pc = 1'b0; m_sc = 1'b0;
         m_fin = 1'b0; m_q.delete(); m_out = 0;
      end else begin
         sz   = m_q.size();
         rdy  = !m_pc && (sz < DEPTH);
         hv   = (sz > 0) && !m_sc && !m_pc && (m_out < MOUT);
         fin  = acc_valid && rdy;
         fout = hv && host_ready;
         nout = m_out + (fout ? 1 : 0) - ((host_done && m_out > 0) ? 1 : 0);
         if (!m_pc) m_fin = 1'b0;
         else if (sz == 0 && m_out == 0) m_fin = 1'b1;
         if (m_pc) m_q.delete();
         else begin
            if (fout) void'(m_q.pop_front());
            if (fin)  m_q.push_back(int'(acc_data));
         end
         m_out = nout;
         if (csr_we) begin
            m_cr = csr_wdata[48];
            m_pm = csr_wdata[47:32];
            m_pc = csr_wdata[15];
            m_sc = csr_wdata[0];
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   task automatic compare();
      logic [1:0]  eps, ess;
      logic [63:0] ew;
      bit          erdy, ehv;
      eps  = m_pc ? (m_fin ? 2'b11 : 2'b01) : 2'b00;
      ess  = (m_sc && m_out != 0) ? 2'b01 : 2'b00;
      ew   = '0;
      ew[48] = m_cr; ew[47:32] = m_pm; ew[25:24] = eps;
      ew[15] = m_pc; ew[9:8] = ess; ew[0] = m_sc;
      erdy = !m_pc && (m_q.size() < DEPTH);
      ehv  = (m_q.size() > 0) && !m_sc && !m_pc && (m_out < MOUT);
      // R2 writable fields read back
      chk(csr_rdata[48] == m_cr && csr_rdata[47:32] == m_pm &&
          csr_rdata[15] == m_pc && csr_rdata[0] == m_sc,
          "R2 control fields", csr_rdata, ew);
      chk(csr_rdata[25:24] == eps, "R6 purge status", 64'(csr_rdata[25:24]), 64'(eps));
      chk(csr_rdata[9:8] == ess, "R7 suspend status", 64'(csr_rdata[9:8]), 64'(ess));
      chk((csr_rdata & ~USED_MASK) == 64'h0, "R8 reserved bits zero",
          csr_rdata & ~USED_MASK, 64'h0);
      chk(cfg_model == m_pm[7:0] && cfg_lpid_chk == m_pm[9] &&
          cfg_pid_chk == m_pm[10] && cfg_lpc_en == m_pm[11], "R3 model decode",
          {52'h0, cfg_lpc_en, cfg_pid_chk, cfg_lpid_chk, 1'b0, cfg_model},
          {52'h0, m_pm[11:9], 1'b0, m_pm[7:0]});
      chk(slice_active == (slice_enable && !m_cr), "R9 enable lock",
          64'(slice_active), 64'(slice_enable && !m_cr));
      chk(acc_ready == erdy, m_pc ? "R5 acc_ready in purge" :
          (m_sc ? "R4 acc_ready in suspend" : "R10 acc_ready"),
          64'(acc_ready), 64'(erdy));
      chk(host_valid == ehv, m_pc ? "R5 host_valid in purge" :
          (m_sc ? "R4 host_valid in suspend" : "R10 host_valid"),
          64'(host_valid), 64'(ehv));
      if (ehv && host_valid)
         chk(host_data == DW'(m_q[0]), "R10 issue order",
             64'(host_data), 64'(DW'(m_q[0])));
   endtask

   task automatic step(input int pv, input int pr, input int pd);
      @(negedge clk);
      csr_we     = 1'b0;
      acc_valid  = ($urandom % 100) < pv;
      acc_data   = DW'(seq);
      seq++;
      host_ready = ($urandom % 100) < pr;
      host_done  = ($urandom % 100) < pd;
      slice_enable = ($urandom % 4) != 0;
      #1 compare();
   endtask

   task automatic run(input int n, input int pv, input int pr, input int pd);
      for (int i = 0; i < n; i++) step(pv, pr, pd);
   endtask

   task automatic wr(input logic [63:0] w);
      @(negedge clk);
      csr_we     = 1'b1;
      csr_wdata  = w;
      acc_valid  = 1'b0;
      host_ready = 1'b0;
      host_done  = 1'b0;
      #1 compare();
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      slice_enable = 1'b1;
      #1;
      // R1 reset state: lock set, all else clear, queue empty
      chk(csr_rdata == 64'h0001_0000_0000_0000, "R1 reset word",
          csr_rdata, 64'h0001_0000_0000_0000);
      chk(!host_valid && acc_ready, "R1 reset queue",
          {62'h0, host_valid, acc_ready}, 64'h1);
      chk(!slice_active, "R1 lock after reset", 64'(slice_active), 64'h0);
      compare();

      // unlock, dedicated-process model, normal traffic (R10)
      wr(64'h0000_0002_0000_0000);
      run(300, 70, 60, 40);
      // fill to full with the host stalled
      run(20, 100, 0, 0);
      // R4 suspend with transactions in flight, then drain
      run(6, 0, 100, 0);
      wr(64'h0000_0002_0000_0001);
      run(100, 50, 100, 20);
      wr(64'h0000_0002_0000_0000);
      run(100, 60, 70, 40);
      // R5/R6 purge with outstanding work and a full queue
      run(8, 100, 100, 0);
      run(6, 100, 0, 0);
      wr(64'h0000_0002_0000_8000);
      run(12, 100, 100, 0);
      run(40, 100, 100, 50);
      wr(64'h0000_0002_0000_0000);
      run(50, 70, 60, 40);
      // R8 all ones: status and reserved ignored, lock set (R9)
      wr(64'hFFFF_FFFF_FFFF_FFFF);
      run(30, 80, 80, 50);
      // R3 feature enables
      wr(64'h0000_0E04_0000_0000);
      run(20, 50, 50, 50);
      wr(64'h0000_0A01_0000_0000);
      run(200, 60, 50, 45);
      // suspend and purge together, then release
      wr(64'h0000_0001_0000_8001);
      run(20, 60, 60, 60);
      wr(64'h0000_0000_0000_0000);
      run(100, 80, 40, 30);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule